// File: doc/BRIEF.md
# Six-Step Irregular Code Sequencer

This block is a clocked Moore machine that walks a closed loop of six 4-bit codes that do not follow binary order. The loop is 1101, 1011, 0111, 0101, 0011, 0010, and then back to 1101. The current code is the output. A separate flag is high while the code is 1101, so downstream logic can tell where each loop begins.

The state is held in four D flip-flops, one per bit. The next value of each bit comes from its own equation. Each equation depends only on the four current bits and the synchronous reset.

Reset is active high and acts only at a rising clock edge. An active-high advance enable lets the sequence step; when the enable is low, the code is held. Reset always wins over the enable.

If the register ever holds one of the ten codes outside the loop, the next edge forces it to 1101. The machine therefore cannot lock up.

Top module: `seq_code_gen`

## Requirements
- R1: When `rst` is high at a rising edge of `clk`, `code_o` becomes 4'b1101 after that edge, whatever the previous code was. Reset is synchronous: raising `rst` between edges does not change `code_o` before the next edge.
- R2: With `rst` low and `adv_en` high, successive edges step `code_o` in the order 4'b1101, 4'b1011, 4'b0111, 4'b0101, 4'b0011, 4'b0010.
- R3: With `rst` low and `adv_en` high, the edge that follows code 4'b0010 loads 4'b1101, so the six codes repeat.
- R4: If the state holds any of the ten codes outside the six-code loop, the next edge with `rst` low and `adv_en` high loads 4'b1101.
- R5: With `rst` low and `adv_en` low, an edge leaves `code_o` unchanged.
- R6: Reset has priority over the enable: `rst` high with `adv_en` low still loads 4'b1101.
- R7: `cycle_start_o` is 1 exactly while `code_o` is 4'b1101, and 0 for every other code.
- R8: The outputs depend only on the stored state. Changing `rst` or `adv_en` between clock edges does not change `code_o` or `cycle_start_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, loads 4'b1101 |
| adv_en | input | 1 | Advance enable, active high; when low the code is held |
| code_o | output | 4 | Current state code |
| cycle_start_o | output | 1 | High while the code is 4'b1101 |

## Verification
The bench runs the loop twice and checks the wrap from 0010 to 1101. A design with a wrong edge in the table would leave the order, or jump back to the start early.

Each of the ten unused codes is placed into the state register, and the bench checks that the next edge returns to 1101. A design that lacks a default branch would wander or stick in a private loop.

A reset in the middle of the loop, and a reset with the enable low, must both return to 1101 on the next edge. A design that gates reset with the enable would keep its old code.

Toggling the inputs between edges must leave the outputs still. A design with a combinational path from an input to the output, or an asynchronous reset, would move them.

// File: rtl/seq_code_pkg.sv
package seq_code_pkg;

   localparam int CODE_BITS = 4;
   localparam int LOOP_LEN  = 6;

   typedef logic [CODE_BITS-1:0] code_t;

   localparam code_t START_CODE = 4'b1101;

   // successor inside the loop; every code outside it maps to the start
   function automatic code_t loop_succ(input code_t cur);
      code_t nx;
      case (cur)
         4'b1101: nx = 4'b1011;
         4'b1011: nx = 4'b0111;
         4'b0111: nx = 4'b0101;
         4'b0101: nx = 4'b0011;
         4'b0011: nx = 4'b0010;
         4'b0010: nx = START_CODE;
         default: nx = START_CODE;
      endcase
      return nx;
   endfunction

   function automatic logic in_loop(input code_t cur);
      logic hit;
      case (cur)
         4'b1101, 4'b1011, 4'b0111,
         4'b0101, 4'b0011, 4'b0010: hit = 1'b1;
         default:                   hit = 1'b0;
      endcase
      return hit;
   endfunction

endpackage

// File: rtl/seq_bit_next.sv
module seq_bit_next
   import seq_code_pkg::*;
#(
   parameter int BIT_IDX = 0
) (
   input  code_t cur_state,
   input  logic  rst,
   output logic  nxt_bit
);

   initial begin
      assert (BIT_IDX >= 0 && BIT_IDX < CODE_BITS)
         else $error("seq_bit_next: BIT_IDX out of range");
   end

   code_t succ;

   always_comb begin
      succ    = loop_succ(cur_state);
      nxt_bit = rst ? START_CODE[BIT_IDX] : succ[BIT_IDX];
   end

endmodule

// File: rtl/seq_start_dec.sv
module seq_start_dec
   import seq_code_pkg::*;
#(
   parameter code_t MARK_CODE = START_CODE
) (
   input  code_t code_in,
   output logic  mark_o
);

   always_comb mark_o = (code_in == MARK_CODE);

endmodule

// File: rtl/seq_code_gen.sv
module seq_code_gen
   import seq_code_pkg::*;
#(
   parameter int WIDTH      = 4,
   parameter bit USE_ENABLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             adv_en,
   output logic [WIDTH-1:0] code_o,
   output logic             cycle_start_o
);

   initial begin
      assert (WIDTH == CODE_BITS)
         else $error("seq_code_gen: WIDTH must equal the code width");
      assert (LOOP_LEN == 6)
         else $error("seq_code_gen: loop length mismatch");
   end

   code_t state_q;
   code_t state_d;
   logic  adv;

   generate
      if (USE_ENABLE) begin : g_gated
         assign adv = adv_en;
      end else begin : g_free
         logic unused_en;
         assign unused_en = adv_en;
         assign adv = 1'b1;
      end
   endgenerate

   // one next-state equation per flip-flop
   genvar gi;
   generate
      for (gi = 0; gi < WIDTH; gi++) begin : g_bit
         seq_bit_next #(.BIT_IDX(gi)) u_nx (
            .cur_state(state_q),
            .rst      (rst),
            .nxt_bit  (state_d[gi])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst || adv) state_q <= state_d;
   end

   seq_start_dec u_mark (
      .code_in(state_q),
      .mark_o (cycle_start_o)
   );

   assign code_o = state_q;

   // ---------------- assertions ----------------
   logic seen_edge = 1'b0;
   logic rst_d     = 1'b0;
   always_ff @(posedge clk) begin
      seen_edge <= 1'b1;
      rst_d     <= rst;
   end

   assert_reset_start_R1: assert property (@(posedge clk)
      (seen_edge && rst_d) |-> (code_o == START_CODE));

   assert_loop_moves_R2: assert property (@(posedge clk) disable iff (rst)
      (adv && in_loop(state_q)) |=> (code_o != $past(code_o)));

   assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
      (adv && code_o == 4'b0010) |=> (code_o == 4'b1101));

   assert_recover_R4: assert property (@(posedge clk) disable iff (rst)
      (adv && !in_loop(state_q)) |=> (code_o == START_CODE));

   assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
      (!adv) |=> $stable(code_o));

   assert_flag_after_wrap_R7: assert property (@(posedge clk) disable iff (rst)
      (adv && code_o == 4'b0010) |=> cycle_start_o);

endmodule

// File: tb/seq_code_gen_test.sv
module seq_code_gen_test;

   logic       clk = 1'b0;
   logic       rst = 1'b0;
   logic       adv_en = 1'b0;
   logic [3:0] code_o;
   logic       cycle_start_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   seq_code_gen uut (
      .clk          (clk),
      .rst          (rst),
      .adv_en       (adv_en),
      .code_o       (code_o),
      .cycle_start_o(cycle_start_o)
   );

   localparam logic [3:0] LOOP [6] = '{4'b1101, 4'b1011, 4'b0111,
                                       4'b0101, 4'b0011, 4'b0010};

   task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got code/flag %b, expected %b", tag, act, exp);
      end
   endtask

   function automatic logic [4:0] expect_of(input logic [3:0] c);
      return {c, c == 4'b1101};
   endfunction

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      @(negedge clk);
      rst = 1'b1; adv_en = 1'b1;
      step();
      chk("R1 reset state", {code_o, cycle_start_o}, expect_of(4'b1101));
      rst = 1'b0;
   endtask

   task automatic t_two_passes();
      rst = 1'b1; step(); rst = 1'b0; adv_en = 1'b1;
      for (int p = 0; p < 2; p++) begin
         for (int i = 0; i < 6; i++) begin
            chk(i == 0 ? "R3 wrap/R7 flag" : "R2 order",
                {code_o, cycle_start_o}, expect_of(LOOP[i]));
            step();
         end
      end
      chk("R3 wrap after second pass", {code_o, cycle_start_o}, expect_of(4'b1101));
   endtask

   task automatic t_unused();
      logic [3:0] fc;
      for (int v = 0; v < 16; v++) begin
         fc = v[3:0];
         if (fc == 4'b1101 || fc == 4'b1011 || fc == 4'b0111 ||
             fc == 4'b0101 || fc == 4'b0011 || fc == 4'b0010) continue;
         rst = 1'b1; adv_en = 1'b1; step();
         rst = 1'b0; step();
         force uut.state_q = fc;
         #1;
         release uut.state_q;
         chk("R4 forced code present", {code_o, cycle_start_o}, expect_of(fc));
         step();
         chk("R4 recovery to start", {code_o, cycle_start_o}, expect_of(4'b1101));
      end
   endtask

   task automatic t_mid_reset();
      rst = 1'b1; step(); rst = 1'b0; adv_en = 1'b1;
      step(); step(); step();
      chk("R2 third code", {code_o, cycle_start_o}, expect_of(4'b0101));
      rst = 1'b1; step(); rst = 1'b0;
      chk("R1 mid-loop reset", {code_o, cycle_start_o}, expect_of(4'b1101));
   endtask

   task automatic t_hold_and_priority();
      rst = 1'b1; step(); rst = 1'b0; adv_en = 1'b1;
      step(); step();
      chk("R2 before hold", {code_o, cycle_start_o}, expect_of(4'b0111));
      adv_en = 1'b0;
      step(); step(); step();
      chk("R5 hold with enable low", {code_o, cycle_start_o}, expect_of(4'b0111));
      adv_en = 1'b1; step();
      chk("R5 resume after hold", {code_o, cycle_start_o}, expect_of(4'b0101));
      adv_en = 1'b0; rst = 1'b1; step(); rst = 1'b0;
      chk("R6 reset beats enable low", {code_o, cycle_start_o}, expect_of(4'b1101));
      step();
      chk("R5 hold at start code", {code_o, cycle_start_o}, expect_of(4'b1101));
   endtask

   task automatic t_moore();
      rst = 1'b1; step(); rst = 1'b0; adv_en = 1'b1; step();
      chk("R8 setup", {code_o, cycle_start_o}, expect_of(4'b1011));
      #1 rst = 1'b1;
      #1 chk("R8/R1 rst between edges", {code_o, cycle_start_o}, expect_of(4'b1011));
      rst = 1'b0;
      adv_en = 1'b0;
      #1 chk("R8 enable toggled between edges", {code_o, cycle_start_o}, expect_of(4'b1011));
      adv_en = 1'b1;
      step();
      chk("R2 step after toggles", {code_o, cycle_start_o}, expect_of(4'b0111));
   endtask

   initial begin
      t_reset();
      t_two_passes();
      t_unused();
      t_mid_reset();
      t_hold_and_priority();
      t_moore();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got running, expected finished");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule